// File: doc/BRIEF.md
# Segment Ring Buffer Address Manager

This block hands out the start addresses of fixed-size segments inside a circular memory region. A producer takes each address from a valid/ready stream, fills that segment, and then reports it finished with a one-cycle pulse. The block keeps a pointer to the next segment to issue and a pointer to the end of the finished data, and it publishes the second one. Software reads the finished data and frees segments by moving its read address forward, which the block watches as a live input.

Before operation the region's first address, its exclusive limit and the read address are placed on configuration inputs. The read address starts equal to the first address, and all three values are whole multiples of the segment size. When `enable` rises, the block latches the region bounds, loads both pointers with the first address and starts offering segments. One segment always stays unused so that a full ring can be told apart from an empty one. The block has no way to be disabled once it is running.

Top module: `seg_ring_mgr`

## Requirements
- R1: During reset and until `enable` is first seen high at a clock edge, `seg_valid` is 0, and `seg_addr` and `wr_addr` both read 0.
- R2: At the clock edge where `enable` is first seen high, `cfg_base` and `cfg_limit` are latched, and both `seg_addr` and `wr_addr` become `cfg_base`.
- R3: `seg_valid` is 1 exactly when the block is running and the address one segment after `seg_addr` (with the wrap of R5) differs from `rd_addr`. The ring therefore never holds more than (limit - base) / SEG_BYTES - 1 outstanding segments.
- R4: `seg_addr` moves to the next segment only at an edge where `seg_valid` and `seg_ready` are both 1, and stays unchanged at every other edge.
- R5: The next segment after address A is A + SEG_BYTES. When that sum is equal to or greater than the latched limit, the next segment is the latched base instead. The limit is exclusive.
- R6: Each cycle with `seg_written` at 1 moves `wr_addr` forward by one segment, using the wrap of R5. `wr_addr` is unchanged in every other cycle.
- R7: After the block starts, changes on `cfg_base` and `cfg_limit` have no effect on the addresses it issues or on where it wraps.
- R8: While `seg_valid` is 1 and `seg_ready` is 0, `seg_valid` stays 1 and `seg_addr` stays the same.
- R9: An accepted issue and a `seg_written` pulse in the same cycle both take effect at that edge.
- R10: When `rd_addr` moves so that it no longer equals the next segment after `seg_addr`, `seg_valid` rises in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Starts the block on its first high level; it must not be lowered afterwards |
| cfg_base | input | ADDR_W | First byte address of the ring, a multiple of SEG_BYTES |
| cfg_limit | input | ADDR_W | Exclusive end address of the ring, a multiple of SEG_BYTES |
| rd_addr | input | ADDR_W | Consumer read address; segments at and after it up to the issue point are owned by the consumer |
| seg_addr | output | ADDR_W | Start address of the offered segment |
| seg_valid | output | 1 | `seg_addr` holds a free segment |
| seg_ready | input | 1 | Producer takes the offered segment |
| seg_written | input | 1 | One-cycle pulse: the oldest issued segment has been filled |
| wr_addr | output | ADDR_W | Address just past the last filled segment |

## Verification
Two events can land on the same clock edge: the producer accepting an issued segment and the producer reporting a segment as written. Each one moves its own pointer. The bench provokes the overlap by first freeing a segment through `rd_addr`, and then raising `seg_ready` and `seg_written` together for one cycle. It judges the result by checking that `seg_addr` and `wr_addr` have each moved by exactly one segment, and that `seg_valid` then falls because the next segment would reach the read address.

// File: rtl/seg_ring_pkg.sv
package seg_ring_pkg;

  typedef enum logic [0:0] {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } ring_state_e;

endpackage

// File: rtl/seg_ring_cfg.sv
module seg_ring_cfg
  import seg_ring_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  output logic              start_o,
  output logic              running_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] limit_o
);

  ring_state_e       state_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] limit_q;

  // start event: first edge that sees enable while still waiting
  assign start_o   = (state_q == ST_WAIT) && enable;
  assign running_o = (state_q == ST_RUN);
  assign base_o    = base_q;
  assign limit_o   = limit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      base_q  <= '0;
      limit_q <= '0;
    end else if (start_o) begin
      state_q <= ST_RUN;
      base_q  <= base_i;
      limit_q <= limit_i;
    end
  end

endmodule

// File: rtl/seg_ring_ptr.sv
module seg_ring_ptr #(
  parameter int ADDR_W    = 16,
  parameter int SEG_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] nxt_o
);

  localparam logic [ADDR_W:0] STEP = (ADDR_W + 1)'(SEG_BYTES);

  // one segment forward, back to base when the exclusive limit is reached
  function automatic logic [ADDR_W-1:0] step_wrap(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] b,
    input logic [ADDR_W-1:0] l
  );
    logic [ADDR_W:0] sum;
    sum = {1'b0, a} + STEP;
    if (sum >= {1'b0, l}) return b;
    return sum[ADDR_W-1:0];
  endfunction

  logic [ADDR_W-1:0] ptr_q;

  assign ptr_o = ptr_q;
  assign nxt_o = step_wrap(ptr_q, base_i, limit_i);

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (adv_i)  ptr_q <= nxt_o;
  end

endmodule

// File: rtl/seg_ring_mgr.sv
module seg_ring_mgr #(
  parameter int ADDR_W    = 16,
  parameter int SEG_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] seg_addr,
  output logic              seg_valid,
  input  logic              seg_ready,
  input  logic              seg_written,
  output logic [ADDR_W-1:0] wr_addr
);

  localparam int NPTR    = 2;
  localparam int P_ISSUE = 0;
  localparam int P_WRIT  = 1;

  logic              start_w;
  logic              running_w;
  logic [ADDR_W-1:0] base_q_w;
  logic [ADDR_W-1:0] limit_q_w;
  logic              accept_w;
  logic              full_w;
  logic [NPTR-1:0]   adv_w;
  logic [ADDR_W-1:0] ptr_w [NPTR];
  logic [ADDR_W-1:0] nxt_w [NPTR];

  seg_ring_cfg #(.ADDR_W(ADDR_W)) i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .base_i    (cfg_base),
    .limit_i   (cfg_limit),
    .start_o   (start_w),
    .running_o (running_w),
    .base_o    (base_q_w),
    .limit_o   (limit_q_w)
  );

  assign adv_w[P_ISSUE] = accept_w;
  assign adv_w[P_WRIT]  = running_w && seg_written;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    seg_ring_ptr #(.ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)) i_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start_w),
      .load_val_i (cfg_base),
      .adv_i      (adv_w[g]),
      .base_i     (base_q_w),
      .limit_i    (limit_q_w),
      .ptr_o      (ptr_w[g]),
      .nxt_o      (nxt_w[g])
    );
  end

  // one slot always stays unused: stop when the next issue would meet rd_addr
  assign full_w    = (nxt_w[P_ISSUE] == rd_addr);
  assign seg_valid = running_w && !full_w;
  assign accept_w  = seg_valid && seg_ready;
  assign seg_addr  = ptr_w[P_ISSUE];
  assign wr_addr   = ptr_w[P_WRIT];

endmodule

// File: rtl/seg_ring_mgr_chk.sv
module seg_ring_mgr_chk #(
  parameter int ADDR_W    = 16,
  parameter int SEG_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              running,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] limit_q,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] seg_addr,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic              seg_written,
  input logic [ADDR_W-1:0] wr_addr
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !seg_valid);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready) |=> (seg_addr != rd_addr));

  p_moves_on_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready) |=> (seg_addr != $past(seg_addr)));

  p_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(seg_valid && seg_ready)) |=> $stable(seg_addr));

  p_in_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (seg_addr >= base_q && seg_addr < limit_q));

  p_wr_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !seg_written) |=> $stable(wr_addr));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr)));

endmodule

bind seg_ring_mgr seg_ring_mgr_chk #(.ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .running     (running_w),
  .base_q      (base_q_w),
  .limit_q     (limit_q_w),
  .rd_addr     (rd_addr),
  .seg_addr    (seg_addr),
  .seg_valid   (seg_valid),
  .seg_ready   (seg_ready),
  .seg_written (seg_written),
  .wr_addr     (wr_addr)
);

// File: tb/test_seg_ring_mgr.sv
`timescale 1ns/1ps
module test_seg_ring_mgr;

  localparam int AW  = 16;
  localparam int SEG = 64;
  localparam logic [AW-1:0] BASE = 16'h0100;
  localparam logic [AW-1:0] LIM  = 16'h0300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW-1:0] cfg_limit = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [AW-1:0] seg_addr;
  logic          seg_valid;
  logic          seg_ready = 1'b0;
  logic          seg_written = 1'b0;
  logic [AW-1:0] wr_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  seg_ring_mgr #(.ADDR_W(AW), .SEG_BYTES(SEG)) i_seg_ring_mgr (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .rd_addr(rd_addr), .seg_addr(seg_addr),
    .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_written(seg_written), .wr_addr(wr_addr)
  );

  // restated ring step: add a segment, fall back to base at the limit
  function automatic logic [AW-1:0] after(input logic [AW-1:0] a);
    int s;
    s = int'(a) + SEG;
    return (s < int'(LIM)) ? AW'(s) : BASE;
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // take the offered segment, checking it first
  task automatic take(input string tag, input logic [AW-1:0] exp);
    @(negedge clk);
    chk({tag, " valid"}, AW'(seg_valid), AW'(1));
    chk({tag, " addr"}, seg_addr, exp);
    seg_ready = 1'b1;
    tick();
    @(negedge clk);
    seg_ready = 1'b0;
  endtask

  task automatic pulse_written();
    @(negedge clk);
    seg_written = 1'b1;
    tick();
    @(negedge clk);
    seg_written = 1'b0;
  endtask

  task automatic t_reset();
    tick();
    chk("R1 valid in reset", AW'(seg_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    cfg_base = BASE; cfg_limit = LIM; rd_addr = BASE;
    tick(); tick();
    chk("R1 valid before enable", AW'(seg_valid), '0);
    chk("R1 seg_addr before enable", seg_addr, '0);
    chk("R1 wr_addr before enable", wr_addr, '0);
  endtask

  task automatic t_enable();
    @(negedge clk);
    enable = 1'b1;
    tick();
    chk("R2 seg_addr load", seg_addr, BASE);
    chk("R2 wr_addr load", wr_addr, BASE);
    chk("R3 valid when empty", AW'(seg_valid), AW'(1));
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R8 valid held", AW'(seg_valid), AW'(1));
      chk("R8 addr held", seg_addr, BASE);
    end
  endtask

  task automatic t_fill();
    logic [AW-1:0] e;
    e = BASE;
    @(negedge clk);
    cfg_base = 16'h0000; cfg_limit = 16'h0200;  // R7: should be ignored
    for (int i = 0; i < 7; i++) begin
      take("R4 R7 fill", e);
      e = after(e);
    end
    #1;
    chk("R4 addr after seven takes", seg_addr, 16'h02C0);
    chk("R3 full stops valid", AW'(seg_valid), '0);
    @(negedge clk);
    seg_ready = 1'b1;
    tick();
    @(negedge clk);
    seg_ready = 1'b0;
    chk("R4 ready without valid ignored", seg_addr, 16'h02C0);
  endtask

  task automatic t_written();
    for (int i = 0; i < 3; i++) pulse_written();
    chk("R6 wr_addr after three pulses", wr_addr, 16'h01C0);
    chk("R4 issue untouched by writes", seg_addr, 16'h02C0);
  endtask

  task automatic t_free_wrap();
    @(negedge clk);
    rd_addr = 16'h01C0;
    #1;
    chk("R10 valid returns at once", AW'(seg_valid), AW'(1));
    take("R5 last segment", 16'h02C0);
    take("R5 wrapped to base", BASE);
    take("R5 after wrap", 16'h0140);
    #1;
    chk("R3 full again", AW'(seg_valid), '0);
    chk("R3 issue parked", seg_addr, 16'h0180);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    rd_addr = 16'h0200;
    #1;
    chk("R10 valid after free", AW'(seg_valid), AW'(1));
    seg_ready = 1'b1;
    seg_written = 1'b1;
    tick();
    @(negedge clk);
    seg_ready = 1'b0;
    seg_written = 1'b0;
    chk("R9 issue moved", seg_addr, 16'h01C0);
    chk("R9 written moved", wr_addr, 16'h0200);
    chk("R9 R3 full after both", AW'(seg_valid), '0);
  endtask

  task automatic t_wr_wrap();
    for (int i = 0; i < 4; i++) pulse_written();
    chk("R6 R5 wr_addr wrapped", wr_addr, BASE);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_enable();
        t_hold();
        t_fill();
        t_written();
        t_free_wrap();
        t_same_cycle();
        t_wr_wrap();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule